// File: doc/BRIEF.md
# Dithered PWM Duty Sequencer

This block sits beside a PWM counter and chooses the compare value for each PWM period. It alternates between a base count and the next count up. Over a sequence of 2^n periods, a programmed number of those periods use the higher count. The average duty therefore gains n fractional bits beyond the counter's native resolution. The higher periods are spread evenly through the sequence by a signed error accumulator. At the start of each sequence the accumulator is set to half the sequence length. On every period the upper count is subtracted from it. A result below zero selects the higher count and adds the sequence length back.

The PWM core pulses `start_i` once per period. The new compare value appears on `comp_o` on the next cycle. Settings are sampled only on the strobe that opens a sequence. In repeat mode the sequence keeps replaying its stored settings and sends no end-of-sequence pulse. Otherwise the sequence takes fresh settings at each boundary and pulses `eos_irq_o` when it completes, so new values can be supplied.

Top module: `dither_duty_seq`

## Requirements
- R1: After reset, `comp_o` is 0 and `eos_irq_o` is 0.
- R2: With sequence length L, the accumulator starts each sequence at L/2. Each period subtracts the upper count u. A negative result selects base+1 and adds L back. A zero or positive result selects the base value.
- R3: Each sequence holds exactly u periods at base+1. A value of u above L is treated as L, so u=0 gives only base values and u>=L gives only base+1.
- R4: With base 37, u=12 and L=16, the sequence is 38,37,38,38 repeated four times.
- R5: The length field `nlog_i` gives L = 2^nlog_i. A value above LOG_MAX is treated as LOG_MAX. With n=0 every sequence is one period long.
- R6: `comp_o` never exceeds the period length `plen_i` sampled with the sequence. A larger candidate is replaced by `plen_i`.
- R7: Base, upper count, length and period length are sampled only on the strobe that starts a sequence. Changes made during a sequence have no effect until the next boundary.
- R8: When `repeat_i` is 1 at a boundary after the first sequence, the stored settings are reused, input settings are ignored, and no end-of-sequence pulse is given.
- R9: When `repeat_i` was 0 at the boundary, `eos_irq_o` is high for exactly the one cycle after the strobe of the sequence's last period.
- R10: `comp_o` changes only on the cycle after a `start_i` strobe and holds between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse at each PWM period start |
| base_i | input | CNT_W | Lower compare count |
| upn_i | input | LOG_MAX+1 | Number of base+1 periods per sequence |
| nlog_i | input | NW | log2 of sequence length |
| plen_i | input | CNT_W | PWM period length, clamp for the compare value |
| repeat_i | input | 1 | 1: replay stored settings; 0: reload and signal at end |
| comp_o | output | CNT_W | Compare value for the current period |
| eos_irq_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
On every cycle, the assertions check the following:
- the accumulator range between steps;
- that the per-sequence tally of upper periods equals the programmed count;
- the clamp against the period length;
- that `comp_o` holds between strobes;
- that stored settings stay frozen inside a sequence;
- that end-of-sequence pulses appear only after a strobe and never in repeat mode.

Only the bench scenarios can show the exact order of base and upper periods for every length and count, and the worked 16-period pattern. They also show that settings changed mid-sequence or during repeat mode are ignored and then picked up at the next boundary.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;
endpackage

// File: rtl/dseq_cfg.sv
module dseq_cfg
  import dseq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int LOG_MAX = 4,
  parameter int UW      = LOG_MAX + 1,
  parameter int NW      = $clog2(LOG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic [UW-1:0]    upn_i,
  input  logic [NW-1:0]    nlog_i,
  input  logic [CNT_W-1:0] plen_i,
  input  logic             rep_i,
  output logic [CNT_W-1:0] base_o,
  output logic [UW-1:0]    upn_o,
  output logic [NW-1:0]    nlog_o,
  output logic [CNT_W-1:0] plen_o,
  output logic             rep_o
);
  phase_e           phase_q, phase_n;
  logic [CNT_W-1:0] base_q, plen_q;
  logic [UW-1:0]    upn_q, len_new, upn_sat;
  logic [NW-1:0]    nlog_q, nlog_sat;
  logic             rep_q, keep, take;

  always_comb begin
    nlog_sat = (int'(nlog_i) > LOG_MAX) ? NW'(LOG_MAX) : nlog_i;
    len_new  = UW'(1) << nlog_sat;
    upn_sat  = (upn_i > len_new) ? len_new : upn_i;
    keep     = (phase_q == PH_RUN) && rep_i;
    take     = load_i && !keep;
    base_o   = take ? base_i   : base_q;
    upn_o    = take ? upn_sat  : upn_q;
    nlog_o   = take ? nlog_sat : nlog_q;
    plen_o   = take ? plen_i   : plen_q;
    rep_o    = load_i ? rep_i  : rep_q;
    phase_n  = load_i ? PH_RUN : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      base_q  <= '0;
      upn_q   <= '0;
      nlog_q  <= '0;
      plen_q  <= '0;
      rep_q   <= 1'b0;
    end else if (load_i) begin
      phase_q <= phase_n;
      base_q  <= base_o;
      upn_q   <= upn_o;
      nlog_q  <= nlog_o;
      plen_q  <= plen_o;
      rep_q   <= rep_o;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(base_q) && $stable(upn_q) && $stable(nlog_q) && $stable(plen_q))); // R7
  AST_REPEAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && phase_q == PH_RUN && rep_i) |=> ($stable(base_q) && $stable(upn_q) && $stable(nlog_q))); // R8
endmodule

// File: rtl/dseq_accum.sv
module dseq_accum #(
  parameter int LOG_MAX = 4,
  parameter int UW      = LOG_MAX + 1,
  parameter int NW      = $clog2(LOG_MAX + 1),
  parameter int AW      = LOG_MAX + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [NW-1:0] nlog_i,
  input  logic [UW-1:0] upn_i,
  output logic          bound_o,
  output logic          last_o,
  output logic          upper_o
);
  logic [LOG_MAX-1:0]   pos_q, pos_n;
  logic signed [AW-1:0] acc_q, acc_n, acc0, diff, len_s;
  logic [UW-1:0]        len, tally_q, tally_n, tally_base;

  always_comb begin
    len        = UW'(1) << nlog_i;
    len_s      = $signed({1'b0, len});
    bound_o    = (pos_q == '0);
    last_o     = (pos_q == LOG_MAX'(len - UW'(1)));
    pos_n      = last_o ? '0 : pos_q + LOG_MAX'(1);
    acc0       = bound_o ? $signed({1'b0, len >> 1}) : acc_q;
    diff       = acc0 - $signed({1'b0, upn_i});
    upper_o    = diff < 0;
    acc_n      = upper_o ? diff + len_s : diff;
    tally_base = bound_o ? '0 : tally_q;
    tally_n    = tally_base + UW'(upper_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      acc_q   <= '0;
      tally_q <= '0;
    end else if (step_i) begin
      pos_q   <= pos_n;
      acc_q   <= acc_n;
      tally_q <= tally_n;
    end
  end

  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !bound_o |-> (acc_q >= 0 && acc_q < len_s)); // R2
  AST_UPPER_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && last_o) |-> (tally_n == upn_i)); // R3
endmodule

// File: rtl/dither_duty_seq.sv
module dither_duty_seq #(
  parameter int CNT_W   = 8,
  parameter int LOG_MAX = 4,
  localparam int UW     = LOG_MAX + 1,
  localparam int NW     = $clog2(LOG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic [UW-1:0]    upn_i,
  input  logic [NW-1:0]    nlog_i,
  input  logic [CNT_W-1:0] plen_i,
  input  logic             repeat_i,
  output logic [CNT_W-1:0] comp_o,
  output logic             eos_irq_o
);
  logic             bound, last, upper, load;
  logic [CNT_W-1:0] base_e, plen_e, comp_n;
  logic [UW-1:0]    upn_e;
  logic [NW-1:0]    nlog_e;
  logic             rep_e, irq_n;
  logic [CNT_W:0]   cand;

  assign load = start_i && bound;

  dseq_cfg #(.CNT_W(CNT_W), .LOG_MAX(LOG_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .base_i(base_i), .upn_i(upn_i), .nlog_i(nlog_i), .plen_i(plen_i), .rep_i(repeat_i),
    .base_o(base_e), .upn_o(upn_e), .nlog_o(nlog_e), .plen_o(plen_e), .rep_o(rep_e)
  );

  dseq_accum #(.LOG_MAX(LOG_MAX)) u_acc (
    .clk(clk), .rst_n(rst_n), .step_i(start_i),
    .nlog_i(nlog_e), .upn_i(upn_e),
    .bound_o(bound), .last_o(last), .upper_o(upper)
  );

  always_comb begin
    cand   = {1'b0, base_e} + (CNT_W+1)'(upper);
    comp_n = (cand > {1'b0, plen_e}) ? plen_e : cand[CNT_W-1:0];
    irq_n  = start_i && last && !rep_e;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_o    <= '0;
      eos_irq_o <= 1'b0;
    end else begin
      eos_irq_o <= irq_n;
      if (start_i) comp_o <= comp_n;
    end
  end

  AST_COMP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (comp_o <= $past(plen_e))); // R6
  AST_COMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(comp_o)); // R10
  AST_IRQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    eos_irq_o |-> $past(start_i)); // R9
  AST_NO_IRQ_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && rep_e) |=> !eos_irq_o); // R8
endmodule

// File: tb/tb_dither_duty_seq.sv
module tb_dither_duty_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int LOG_MAX = 4;
  localparam int UW = LOG_MAX + 1;
  localparam int NW = $clog2(LOG_MAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] base_i = '0, plen_i = '0;
  logic [UW-1:0] upn_i = '0;
  logic [NW-1:0] nlog_i = '0;
  logic repeat_i = 1'b0;
  logic [CNT_W-1:0] comp_o;
  logic eos_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int alt_b, alt_u, alt_n, alt_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_duty_seq #(.CNT_W(CNT_W), .LOG_MAX(LOG_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .upn_i(upn_i),
    .nlog_i(nlog_i), .plen_i(plen_i), .repeat_i(repeat_i),
    .comp_o(comp_o), .eos_irq_o(eos_irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_in(input int b, input int u, input int n, input int p, input bit r);
    base_i = CNT_W'(b); upn_i = UW'(u); nlog_i = NW'(n); plen_i = CNT_W'(p); repeat_i = r;
  endtask

  task automatic strobe();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  // Expected sequence from the requirement's accumulator rule (R2, R3, R6, R9, R10)
  task automatic run_seq(input int eb, input int eu, input int en, input int ep,
                         input bit eirq, input string tag, input int swap_k);
    int len = 1 << en;
    int uc = (eu > len) ? len : eu;
    int acc = len / 2;
    int ups = 0;
    for (int k = 0; k < len; k++) begin
      int v;
      bit up;
      if (k == swap_k) set_in(alt_b, alt_u, alt_n, alt_p, repeat_i);
      strobe();
      acc = acc - uc;
      up = (acc < 0);
      if (up) acc = acc + len;
      v = up ? eb + 1 : eb;
      if (v > ep) v = ep;
      chk(tag, int'(comp_o), v);
      chk({tag, " R9 irq"}, int'(eos_irq_o), (k == len - 1 && eirq) ? 1 : 0);
      if (int'(comp_o) == eb + 1) ups++;
      @(negedge clk);
      chk({tag, " R10 hold"}, int'(comp_o), v);
      chk({tag, " R9 pulse width"}, int'(eos_irq_o), 0);
    end
    if (eb + 1 <= ep) chk({tag, " R3 count"}, ups, uc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 comp", int'(comp_o), 0);
    chk("R1 irq", int'(eos_irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 comp after release", int'(comp_o), 0);

    // R4 worked example
    set_in(37, 12, 4, 160, 1'b0);
    run_seq(37, 12, 4, 160, 1'b1, "R4", -1);

    // R2 / R3 / R5 sweep over every length and upper count, including saturation
    for (int n = 0; n <= LOG_MAX; n++) begin
      for (int u = 0; u <= (1 << n) + 1; u++) begin
        set_in(5 + n, u, n, 200, 1'b0);
        run_seq(5 + n, u, n, 200, 1'b1, (n == 0) ? "R5" : "R2", -1);
      end
    end
    // R5 length field above LOG_MAX saturates to 2^LOG_MAX
    set_in(20, 3, 7, 200, 1'b0);
    run_seq(20, 3, LOG_MAX, 200, 1'b1, "R5 sat", -1);

    // R6 clamp: base+1 exceeds the period length, and base itself above it
    set_in(10, 8, 3, 10, 1'b0);
    run_seq(10, 8, 3, 10, 1'b1, "R6 upper", -1);
    set_in(50, 3, 2, 40, 1'b0);
    run_seq(50, 3, 2, 40, 1'b1, "R6 base", -1);

    // R7 mid-sequence change ignored, taken at the next boundary
    alt_b = 90; alt_u = 1; alt_n = 2; alt_p = 200;
    set_in(30, 5, 3, 200, 1'b0);
    run_seq(30, 5, 3, 200, 1'b1, "R7 old", 2);
    run_seq(90, 1, 2, 200, 1'b1, "R7 new", -1);

    // R8 repeat mode keeps stored settings and suppresses the pulse
    set_in(60, 3, 3, 200, 1'b0);
    run_seq(60, 3, 3, 200, 1'b1, "R8 setup", -1);
    set_in(60, 3, 3, 200, 1'b1);
    run_seq(60, 3, 3, 200, 1'b0, "R8 repeat", -1);
    set_in(12, 7, 1, 100, 1'b1);
    run_seq(60, 3, 3, 200, 1'b0, "R8 ignore", -1);
    set_in(12, 7, 1, 100, 1'b0);
    run_seq(12, 7, 1, 100, 1'b1, "R8 reload", -1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule